// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block produces the serial bit clock and the left/right frame clock for a two-channel audio port from a single master clock. Two configuration pins select one of three clock-master speeds or clock-slave operation. A further select tells the block that the master clock runs at twice the base rate, so that an extra divide-by-two is applied first. In a master speed, the block drives both clocks and raises their output enables. In slave operation, it leaves the pins undriven and hands the externally supplied clocks through to its outputs for the rest of the chip.

The frame clock always runs at the sample rate and the bit clock at 64 times the sample rate. The number of master-clock cycles per bit-clock period (P) sets the master-clock to sample-rate ratio, which is 64·P. P is 4 at single speed, 2 at double speed and 1 at quad speed, and the fast select doubles P. At quad speed with the base-rate master clock, P is 1. In that case the bit clock is the master clock itself, inverted so that its falling edge lines up with the master-clock rising edge. While reset is low the block is powered down: both clock outputs and both enables stay low. The configuration pins are captured only during reset, and all dividers restart from one fixed phase when reset is released.

Top module: `audio_clkgen`

## Requirements
- R1: Configuration code 0 selects master at single speed, code 1 selects master at double speed and code 2 selects master at quad speed. For these codes `speed_code` equals the code and `is_master` is 1. Code 3 selects slave with `speed_code` = 3 and `is_master` = 0.
- R2: In a master speed, `lrclk_o` is a square wave with a period of 64·P master-clock cycles and 50% duty. It is low for the first half-period after reset release.
- R3: In a master speed, `bclk_o` makes exactly 32 rising transitions in every half-period of `lrclk_o`.
- R4: With `fast_mclk` = 1, P is doubled, so the frame lasts 512, 256 or 128 master-clock cycles at single, double or quad speed. With `fast_mclk` = 0 the frame lasts 256, 128 or 64 cycles.
- R5: At quad speed with `fast_mclk` = 0, `bclk_o` is low while `mclk` is high and high while `mclk` is low.
- R6: In a master speed, `lrclk_o` changes only when `bclk_o` falls.
- R7: In slave operation, both output enables are 0, `bclk_o` equals `ext_bclk`, and `lrclk_o` equals `ext_lrclk`.
- R8: In a master speed, both output enables are 1 from the first `mclk` rising edge after reset release onward.
- R9: While `rst_n` is low, `bclk_o`, `lrclk_o`, `bclk_oe` and `lrclk_oe` are all 0, whatever the configuration or external clocks.
- R10: Let the i-th `mclk` rising edge after reset release be counted from 1, and let k = log2(P). When P > 1, after that edge `bclk_o` equals bit k−1 of i and `lrclk_o` equals bit k+5 of i. Two blocks released on the same edge therefore stay aligned.
- R11: `mode_sel` and `fast_mclk` are sampled only while `rst_n` is low. Changes to them after release have no effect on any output until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset / power-down |
| mode_sel | input | 2 | Configuration code (sampled in reset) |
| fast_mclk | input | 1 | Master clock at twice the base ratio (sampled in reset) |
| ext_bclk | input | 1 | Bit clock received from the pin in slave operation |
| ext_lrclk | input | 1 | Frame clock received from the pin in slave operation |
| bclk_o | output | 1 | Bit clock, generated or passed through |
| lrclk_o | output | 1 | Frame clock, generated or passed through |
| bclk_oe | output | 1 | Drive enable for the bit-clock pin |
| lrclk_oe | output | 1 | Drive enable for the frame-clock pin |
| speed_code | output | 2 | Decoded speed (0 single, 1 double, 2 quad, 3 slave) |
| is_master | output | 1 | 1 when the block generates the clocks |

## Verification
The assertions assume that reset is held low for at least one `mclk` rising edge, so that the configuration register holds a real value before the checks are enabled. They also assume that the configuration inputs are stable during that edge. The bench holds reset for several edges with fixed configuration pins. It drives all inputs away from the `mclk` rising edge and changes the configuration pins only after release, to exercise R11. The external clocks are used only in slave operation, and the bench drives them just after an edge, well before the next sample point.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2,
    SPD_SLAVE  = 2'd3
  } speed_e;

  localparam int MAX_TAP = 3;
  localparam int TAP_W   = 2;

  // log2 of master-clock cycles per bit-clock period
  function automatic logic [TAP_W-1:0] tap_of(speed_e s, logic fast);
    logic [TAP_W-1:0] base;
    case (s)
      SPD_SINGLE: base = 2'd2;
      SPD_DOUBLE: base = 2'd1;
      default:    base = 2'd0;
    endcase
    return base + {1'b0, fast};
  endfunction

endpackage

// File: rtl/clkgen_cfg.sv
module clkgen_cfg
  import clkgen_pkg::*;
(
  input  logic             mclk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             fast_mclk,
  output speed_e           speed,
  output logic             master,
  output logic [TAP_W-1:0] tap
);

  logic [1:0] mode_q;
  logic       fast_q;

  // capture only while held in reset
  always_ff @(posedge mclk) begin
    if (!rst_n) begin
      mode_q <= mode_sel;
      fast_q <= fast_mclk;
    end
  end

  always_comb begin
    speed  = speed_e'(mode_q);
    master = (mode_q != 2'b11);
    tap    = tap_of(speed, fast_q);
  end

  AST_CFG_FROZEN: assert property (@(posedge mclk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(mode_q) && $stable(fast_q))); // R11

endmodule

// File: rtl/clkgen_divider.sv
module clkgen_divider
  import clkgen_pkg::*;
#(
  parameter int BCLK_PER_FRAME = 64
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [TAP_W-1:0] tap,
  output logic             bclk,
  output logic             lrclk,
  output logic             active
);

  localparam int FR_W  = $clog2(BCLK_PER_FRAME);
  localparam int CNT_W = FR_W + MAX_TAP;
  localparam int HALF  = BCLK_PER_FRAME / 2;
  localparam int RC_W  = FR_W + 1;

  logic [CNT_W-1:0]   cnt;
  logic [MAX_TAP:0]   bclk_cand;
  logic [MAX_TAP:0]   lrclk_cand;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else begin
      active <= en;
      cnt    <= en ? cnt + CNT_W'(1) : '0;
    end
  end

  // tap 0: bit clock is the inverted master clock
  assign bclk_cand[0] = active & ~mclk;

  for (genvar j = 1; j <= MAX_TAP; j++) begin : g_bclk_tap
    assign bclk_cand[j] = cnt[j-1];
  end

  for (genvar j = 0; j <= MAX_TAP; j++) begin : g_lr_tap
    assign lrclk_cand[j] = cnt[j+FR_W-1];
  end

  assign bclk  = bclk_cand[tap];
  assign lrclk = lrclk_cand[tap];

  // checker state: rises of the counter-derived bit clock per half frame
  logic            bclk_reg_prev;
  logic            lr_prev;
  logic [RC_W-1:0] rises;
  logic            bclk_reg;
  logic            lr_chg;

  assign bclk_reg = (tap == '0) ? 1'b0 : bclk_cand[tap];
  assign lr_chg   = (lrclk != lr_prev);

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_reg_prev <= 1'b0;
      lr_prev       <= 1'b0;
      rises         <= '0;
    end else begin
      bclk_reg_prev <= bclk_reg;
      lr_prev       <= lrclk;
      if (lr_chg)
        rises <= '0;
      else if (bclk_reg && !bclk_reg_prev)
        rises <= rises + RC_W'(1);
    end
  end

  AST_LR_ON_BCLK_FALL: assert property (@(posedge mclk) disable iff (!rst_n)
    (lr_chg && tap != '0) |-> (bclk_reg_prev && !bclk_reg)); // R6

  AST_BCLK_PER_HALF: assert property (@(posedge mclk) disable iff (!rst_n)
    (lr_chg && tap != '0) |-> (rises == RC_W'(HALF))); // R3

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import clkgen_pkg::*;
#(
  parameter int BCLK_PER_FRAME = 64
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       fast_mclk,
  input  logic       ext_bclk,
  input  logic       ext_lrclk,
  output logic       bclk_o,
  output logic       lrclk_o,
  output logic       bclk_oe,
  output logic       lrclk_oe,
  output logic [1:0] speed_code,
  output logic       is_master
);

  speed_e           speed;
  logic             master;
  logic [TAP_W-1:0] tap;
  logic             gen_bclk;
  logic             gen_lrclk;
  logic             gen_active;

  clkgen_cfg u_cfg (
    .mclk      (mclk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .fast_mclk (fast_mclk),
    .speed     (speed),
    .master    (master),
    .tap       (tap)
  );

  clkgen_divider #(.BCLK_PER_FRAME(BCLK_PER_FRAME)) u_div (
    .mclk   (mclk),
    .rst_n  (rst_n),
    .en     (master),
    .tap    (tap),
    .bclk   (gen_bclk),
    .lrclk  (gen_lrclk),
    .active (gen_active)
  );

  always_comb begin
    speed_code = speed;
    is_master  = master;
    bclk_oe    = master & gen_active;
    lrclk_oe   = master & gen_active;
    if (!rst_n) begin
      bclk_o  = 1'b0;
      lrclk_o = 1'b0;
    end else if (master) begin
      bclk_o  = gen_bclk;
      lrclk_o = gen_lrclk;
    end else begin
      bclk_o  = ext_bclk;
      lrclk_o = ext_lrclk;
    end
  end

  AST_SLAVE_UNDRIVEN: assert property (@(posedge mclk) disable iff (!rst_n)
    !is_master |-> (!bclk_oe && !lrclk_oe)); // R7

  AST_PWRDN_STATIC: assert property (@(posedge mclk)
    !rst_n |-> (!bclk_o && !lrclk_o && !bclk_oe && !lrclk_oe)); // R9

endmodule

// File: tb/sim_audio_clkgen.sv
module sim_audio_clkgen;

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       fast_mclk = 1'b0;
  logic       ext_bclk = 1'b0;
  logic       ext_lrclk = 1'b0;
  logic       bclk_o, lrclk_o, bclk_oe, lrclk_oe, is_master;
  logic [1:0] speed_code;

  int n_chk = 0;
  int n_bad = 0;

  audio_clkgen u0 (
    .mclk(mclk), .rst_n(rst_n), .mode_sel(mode_sel), .fast_mclk(fast_mclk),
    .ext_bclk(ext_bclk), .ext_lrclk(ext_lrclk),
    .bclk_o(bclk_o), .lrclk_o(lrclk_o), .bclk_oe(bclk_oe), .lrclk_oe(lrclk_oe),
    .speed_code(speed_code), .is_master(is_master)
  );

  always #4 mclk = ~mclk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_cfg(logic [1:0] m, logic f);
    int k;
    logic mst;
    mst = (m != 2'b11);
    k = 2 - int'(m) + int'(f);
    // power-down with configuration applied
    @(negedge mclk);
    rst_n = 1'b0; mode_sel = m; fast_mclk = f;
    ext_bclk = 1'b1; ext_lrclk = 1'b1;
    repeat (4) @(negedge mclk);
    #2;
    check("R9 outputs in reset", {4'd0, bclk_o, lrclk_o, bclk_oe, lrclk_oe}, 8'd0);
    check("R1 speed code", {6'd0, speed_code}, {6'd0, m});
    check("R1 master flag", {7'd0, is_master}, {7'd0, mst});
    @(negedge mclk);
    rst_n = 1'b1;
    for (int i = 1; i <= 1200; i++) begin
      logic eb, el, xb, xl;
      @(posedge mclk);
      #1;
      eb = logic'(i[0] ^ i[2]);
      el = logic'(i[5]);
      ext_bclk = eb; ext_lrclk = el;
      if (i == 600) begin
        mode_sel = ~m; fast_mclk = ~f;  // R11: no effect expected
      end
      #1;
      if (!mst) begin
        check("R7 slave pass-through", {4'd0, bclk_o, lrclk_o, bclk_oe, lrclk_oe},
              {4'd0, eb, el, 2'b00});
        check("R1 slave code", {5'd0, speed_code, is_master}, {5'd0, 2'b11, 1'b0});
      end else begin
        xl = logic'((i >> (k + 5)) & 1);
        xb = (k == 0) ? 1'b0 : logic'((i >> (k - 1)) & 1);
        if (k == 0)
          check("R5 quad base bclk high-phase", {7'd0, bclk_o}, {7'd0, xb});
        else if (f)
          check("R4 fast bclk phase", {7'd0, bclk_o}, {7'd0, xb});
        else
          check("R10 bclk phase", {7'd0, bclk_o}, {7'd0, xb});
        check(i > 600 ? "R11 lrclk after pin change" : "R2 lrclk phase",
              {7'd0, lrclk_o}, {7'd0, xl});
        check("R8 enables", {6'd0, bclk_oe, lrclk_oe}, 8'd3);
        check("R11 code held", {5'd0, speed_code, is_master}, {5'd0, m, 1'b1});
        @(negedge mclk);
        #2;
        if (k == 0)
          check("R5 quad base bclk low-phase", {7'd0, bclk_o}, 8'd1);
        else
          check("R3 bclk steady low-phase", {7'd0, bclk_o}, {7'd0, xb});
      end
    end
  endtask

  initial begin
    for (int m = 0; m < 4; m++)
      for (int f = 0; f < 2; f++)
        run_cfg(2'(m), 1'(f));
    @(negedge mclk);
    rst_n = 1'b0;
    #20;
    check("R9 final reset", {6'd0, bclk_o, lrclk_o}, 8'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule